// File: doc/BRIEF.md
# Address-Encoded System Region Decoder

This block sits on the address bus of a 26-bit processor. For every access it names one target region. The lower half of the space is the translated logical region. Above it come the untranslated physical DRAM window, the I/O window and a top region whose meaning depends on the direction of the access. Reads in the top region go to one of two ROM banks. Writes in the same addresses go instead to the video controller, to the DMA address generators, to the configuration register, or to the page-translation table as an update strobe.

The configuration register is never written through a data bus. The processor performs a write to a chosen address within the DMA/control window, and the register takes its contents from the low address bits of that write. The fields are held until the next such write or reset, and they are exported as separate outputs. They are the page-size code, the ROM access timing, the DRAM refresh mode, the two DMA enables, the OS mode flag and the test flag. Neither the register nor any other decode state can be read back.

Top module: `sys_region_decoder`

## Requirements
- R1: A valid access, read or write, to addresses 0x0000000–0x1FFFFFF asserts `selLogical`.
- R2: A valid access, read or write, to 0x2000000–0x2FFFFFF asserts `selPhysical`.
- R3: A valid access, read or write, to 0x3000000–0x33FFFFF asserts `selIo`, and `ioTiming` is high together with it.
- R4: A valid read from 0x3400000–0x37FFFFF asserts `selRomLow`. A valid read from 0x3800000–0x3FFFFFF asserts `selRomHigh`.
- R5: A valid write to 0x3400000–0x35FFFFF asserts `selVideo`.
- R6: A valid write to 0x3600000–0x37FFFFF asserts `selCtrlReg` when address bits 25:21 are 11011 and bits 19:17 are 111, with bit 20 ignored (for example 0x36E0000 and 0x37E0000). Every other write in that range asserts `selDmaGen`.
- R7: A valid write to 0x3800000–0x3FFFFFF asserts `camUpdate`.
- R8: A control-register write loads the fields at the next rising clock edge, each from its own address bits:
  - `pageSizeCode` from bits 3:2 (00 = 4 KiB, 01 = 8 KiB, 10 = 16 KiB, 11 = 32 KiB)
  - `romTiming` from bits 7:4
  - `refreshMode` from bits 9:8
  - `vidDmaEn` from bit 10
  - `sndDmaEn` from bit 11
  - `osMode` from bit 12
  - `testMode` from bit 13
- R9: While `rstN` is low, and after it is released until the first control-register write, every field reads zero. This gives 4 KiB pages, DMA off and OS mode off.
- R10: While `accValid` is high, exactly one select output is high. While `accValid` is low, none is high.
- R11: The fields do not change on any access other than a valid control-register write. This covers video, DMA, table-update and ROM accesses at any address, and a control-register address presented with `accValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| addr | input | 26 | Processor byte address |
| wrEn | input | 1 | 1 = write, 0 = read |
| accValid | input | 1 | Access in progress this cycle |
| selLogical | output | 1 | Translated logical region |
| selPhysical | output | 1 | Direct physical DRAM window |
| selIo | output | 1 | I/O window |
| ioTiming | output | 1 | Request for I/O bus timing |
| selRomLow | output | 1 | Low ROM bank read |
| selRomHigh | output | 1 | High ROM bank read |
| selVideo | output | 1 | Video controller write |
| selDmaGen | output | 1 | DMA address generator write |
| selCtrlReg | output | 1 | Configuration register write |
| camUpdate | output | 1 | Translation table update strobe |
| pageSizeCode | output | 2 | Page-size code |
| romTiming | output | 4 | ROM access timing field |
| refreshMode | output | 2 | DRAM refresh mode |
| vidDmaEn | output | 1 | Video/cursor DMA enable |
| sndDmaEn | output | 1 | Sound DMA enable |
| osMode | output | 1 | OS mode select |
| testMode | output | 1 | Test mode |

## Verification
The bench builds the block with its default parameters: a 26-bit address and all-zero reset values for the fields. With these values, every region edge sits at its real address. The bench can therefore probe the first and last byte of each window in both directions, including the split between DMA writes and register writes inside 0x3600000–0x37FFFFF, where bit 20 is ignored. The zero reset values allow a mid-run reset to be observed against a register that earlier writes had filled with non-zero patterns.

// File: rtl/regdec_pkg.sv
package regdec_pkg;

  // Low address bits that carry the configuration fields
  localparam int FIELD_LSB = 2;
  localparam int FIELD_W   = 12;
  localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;

  // Upper address bits examined by the region decode
  localparam int KEY_W = 9;

  // Strobes from the decode control to the datapath and the outputs
  typedef struct packed {
    logic logicalHit;
    logic physHit;
    logic ioHit;
    logic romLowHit;
    logic romHighHit;
    logic videoHit;
    logic dmaHit;
    logic ctrlHit;
    logic camHit;
  } regionStrobes_t;

  // Configuration fields; the packed order matches address bits 13:2
  typedef struct packed {
    logic       testMode;
    logic       osMode;
    logic       sndDmaEn;
    logic       vidDmaEn;
    logic [1:0] refreshMode;
    logic [3:0] romTiming;
    logic [1:0] pageSize;
  } ctrlFields_t;

endpackage

// File: rtl/regdec_ctrl.sv
module regdec_ctrl
  import regdec_pkg::*;
#(
  parameter int KEYW = KEY_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [KEYW-1:0]  addrKey,
  input  logic             wrEn,
  input  logic             accValid,
  output regionStrobes_t   strobes
);

  // Bit positions inside the key (key bit KEYW-1 is address bit 25)
  localparam int K_TOP  = KEYW - 1;
  localparam int K_SUB  = KEYW - 3;
  localparam int K_HALF = KEYW - 5;
  localparam int K_IGN  = KEYW - 6;

  logic [1:0] bigRegion;
  logic [1:0] subRegion;
  logic       inLogical, inPhys, inIo, inMid, inTop;
  logic       ctrlKeyMatch;

  assign bigRegion = addrKey[K_TOP -: 2];
  assign subRegion = addrKey[K_SUB -: 2];

  assign inLogical = (bigRegion == 2'b00) || (bigRegion == 2'b01);
  assign inPhys    = (bigRegion == 2'b10);
  assign inIo      = (bigRegion == 2'b11) && (subRegion == 2'b00);
  assign inMid     = (bigRegion == 2'b11) && (subRegion == 2'b01);
  assign inTop     = (bigRegion == 2'b11) && subRegion[1];

  // Register key: 11011 above the ignored bit, 111 below it
  assign ctrlKeyMatch = (addrKey[K_TOP -: 5] == 5'b11011) &&
                        (addrKey[K_IGN-1 -: 3] == 3'b111);

  always_comb begin
    strobes = '0;
    if (accValid) begin
      strobes.logicalHit = inLogical;
      strobes.physHit    = inPhys;
      strobes.ioHit      = inIo;
      strobes.romLowHit  = inMid && !wrEn;
      strobes.romHighHit = inTop && !wrEn;
      strobes.videoHit   = inMid && wrEn && !addrKey[K_HALF];
      strobes.dmaHit     = inMid && wrEn && addrKey[K_HALF] && !ctrlKeyMatch;
      strobes.ctrlHit    = inMid && wrEn && addrKey[K_HALF] && ctrlKeyMatch;
      strobes.camHit     = inTop && wrEn;
    end
  end

  // R10
  single_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> ($countones(strobes) == 1));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (strobes == '0));

  // R7
  cam_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.camHit |-> (wrEn && addrKey[K_TOP -: 3] == 3'b111));

  // R4
  rom_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.romLowHit || strobes.romHighHit) |-> !wrEn);

endmodule

// File: rtl/regdec_data.sv
module regdec_data
  import regdec_pkg::*;
#(
  parameter int          FW      = FIELD_W,
  parameter logic [11:0] RST_VAL = '0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [FW-1:0]  fieldBits,
  input  regionStrobes_t strobes,
  output ctrlFields_t    fields
);

  ctrlFields_t fieldsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      fieldsQ <= ctrlFields_t'(RST_VAL);
    else if (strobes.ctrlHit)
      fieldsQ <= ctrlFields_t'(fieldBits);
  end

  assign fields = fieldsQ;

  // R8
  field_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.ctrlHit) && $past(rstN)) |-> (fields == ctrlFields_t'($past(fieldBits))));

  // R11
  field_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strobes.ctrlHit)) |-> $stable(fields));

endmodule

// File: rtl/sys_region_decoder.sv
module sys_region_decoder
  import regdec_pkg::*;
#(
  parameter int          ADDR_W  = 26,
  parameter logic [11:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              accValid,
  output logic              selLogical,
  output logic              selPhysical,
  output logic              selIo,
  output logic              ioTiming,
  output logic              selRomLow,
  output logic              selRomHigh,
  output logic              selVideo,
  output logic              selDmaGen,
  output logic              selCtrlReg,
  output logic              camUpdate,
  output logic [1:0]        pageSizeCode,
  output logic [3:0]        romTiming,
  output logic [1:0]        refreshMode,
  output logic              vidDmaEn,
  output logic              sndDmaEn,
  output logic              osMode,
  output logic              testMode
);

  localparam int TOP = ADDR_W - 1;

  regionStrobes_t strobes;
  ctrlFields_t    fields;

  regdec_ctrl #(.KEYW(KEY_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addrKey  (addr[TOP -: KEY_W]),
    .wrEn     (wrEn),
    .accValid (accValid),
    .strobes  (strobes)
  );

  regdec_data #(.FW(FIELD_W), .RST_VAL(RST_VAL)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .fieldBits (addr[FIELD_MSB:FIELD_LSB]),
    .strobes   (strobes),
    .fields    (fields)
  );

  assign selLogical  = strobes.logicalHit;
  assign selPhysical = strobes.physHit;
  assign selIo       = strobes.ioHit;
  assign ioTiming    = strobes.ioHit;
  assign selRomLow   = strobes.romLowHit;
  assign selRomHigh  = strobes.romHighHit;
  assign selVideo    = strobes.videoHit;
  assign selDmaGen   = strobes.dmaHit;
  assign selCtrlReg  = strobes.ctrlHit;
  assign camUpdate   = strobes.camHit;

  assign pageSizeCode = fields.pageSize;
  assign romTiming    = fields.romTiming;
  assign refreshMode  = fields.refreshMode;
  assign vidDmaEn     = fields.vidDmaEn;
  assign sndDmaEn     = fields.sndDmaEn;
  assign osMode       = fields.osMode;
  assign testMode     = fields.testMode;

  // R3
  io_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    selIo |-> (accValid && addr[TOP -: 4] == 4'b1100));

  // R2
  phys_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    selPhysical |-> (addr[TOP -: 2] == 2'b10));

endmodule

// File: tb/sim_sys_region_decoder.sv
module sim_sys_region_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  // Vector: {addr[25:0], wr, expected selects[8:0], req[3:0]}
  // select order: logical, phys, io, romLow, romHigh, video, dma, ctrl, cam
  localparam logic [39:0] VECS [NVEC] = '{
    {26'h0000000, 1'b0, 9'b100000000, 4'd1},  // R1
    {26'h1FFFFFF, 1'b1, 9'b100000000, 4'd1},  // R1
    {26'h2000000, 1'b0, 9'b010000000, 4'd2},  // R2
    {26'h2FFFFFF, 1'b1, 9'b010000000, 4'd2},  // R2
    {26'h3000000, 1'b0, 9'b001000000, 4'd3},  // R3
    {26'h33FFFFF, 1'b1, 9'b001000000, 4'd3},  // R3
    {26'h3400000, 1'b0, 9'b000100000, 4'd4},  // R4
    {26'h37FFFFF, 1'b0, 9'b000100000, 4'd4},  // R4
    {26'h3800000, 1'b0, 9'b000010000, 4'd4},  // R4
    {26'h3FFFFFF, 1'b0, 9'b000010000, 4'd4},  // R4
    {26'h3400000, 1'b1, 9'b000001000, 4'd5},  // R5
    {26'h35FFFFF, 1'b1, 9'b000001000, 4'd5},  // R5
    {26'h3600000, 1'b1, 9'b000000100, 4'd6},  // R6
    {26'h36DFFFC, 1'b1, 9'b000000100, 4'd6},  // R6
    {26'h3700000, 1'b1, 9'b000000100, 4'd6},  // R6
    {26'h36E0000, 1'b1, 9'b000000010, 4'd6},  // R6
    {26'h37E0000, 1'b1, 9'b000000010, 4'd6},  // R6 bit 20 ignored
    {26'h3800000, 1'b1, 9'b000000001, 4'd7},  // R7
    {26'h3FFFFFF, 1'b1, 9'b000000001, 4'd7}   // R7
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [25:0] addr = '0;
  logic        wrEn = 1'b0;
  logic        accValid = 1'b0;
  logic selLogical, selPhysical, selIo, ioTiming, selRomLow, selRomHigh;
  logic selVideo, selDmaGen, selCtrlReg, camUpdate;
  logic [1:0] pageSizeCode, refreshMode;
  logic [3:0] romTiming;
  logic vidDmaEn, sndDmaEn, osMode, testMode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_region_decoder u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .accValid(accValid),
    .selLogical(selLogical), .selPhysical(selPhysical), .selIo(selIo),
    .ioTiming(ioTiming), .selRomLow(selRomLow), .selRomHigh(selRomHigh),
    .selVideo(selVideo), .selDmaGen(selDmaGen), .selCtrlReg(selCtrlReg),
    .camUpdate(camUpdate), .pageSizeCode(pageSizeCode), .romTiming(romTiming),
    .refreshMode(refreshMode), .vidDmaEn(vidDmaEn), .sndDmaEn(sndDmaEn),
    .osMode(osMode), .testMode(testMode)
  );

  function automatic logic [8:0] selVec();
    return {selLogical, selPhysical, selIo, selRomLow, selRomHigh,
            selVideo, selDmaGen, selCtrlReg, camUpdate};
  endfunction

  function automatic logic [11:0] fieldVec();
    return {testMode, osMode, sndDmaEn, vidDmaEn, refreshMode, romTiming, pageSizeCode};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [25:0] a, input logic w, input logic v);
    @(negedge clk);
    addr = a; wrEn = w; accValid = v;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    accValid = 1'b0; wrEn = 1'b0; addr = '0;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<5000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 during reset
    check("R9 fields in reset", {4'h0, fieldVec()}, 16'h0000);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R9 after reset
    check("R9 fields after reset", {4'h0, fieldVec()}, 16'h0000);
    // R10 idle
    check("R10 idle selects", {7'h0, selVec()}, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i][39:14], VECS[i][13], 1'b1);
      check($sformatf("R%0d vector %0d", VECS[i][3:0], i), {7'h0, selVec()}, {7'h0, VECS[i][12:4]});
      if (VECS[i][12:4] == 9'b001000000)
        check("R3 ioTiming", {15'h0, ioTiming}, 16'h0001);
    end
    idle();

    // R8 all fields set
    access(26'h36E3FFC, 1'b1, 1'b1);
    idle();
    check("R8 all ones", {4'h0, fieldVec()}, 16'h0FFF);
    check("R8 page 32K", {14'h0, pageSizeCode}, 16'h0003);

    // R8 mixed pattern through the alias with bit 20 set
    access(26'h37E1A54, 1'b1, 1'b1);
    idle();
    check("R8 mixed", {4'h0, fieldVec()}, 16'h0695);
    check("R8 osMode", {15'h0, osMode}, 16'h0001);
    check("R8 romTiming", {12'h0, romTiming}, 16'h0005);

    // R11 accesses that must not touch the register
    access(26'h3403FFC, 1'b1, 1'b1);
    access(26'h3603FFC, 1'b1, 1'b1);
    access(26'h3803FFC, 1'b1, 1'b1);
    access(26'h36E3FFC, 1'b0, 1'b1);
    idle();
    check("R11 other writes/reads", {4'h0, fieldVec()}, 16'h0695);
    access(26'h36E0000, 1'b1, 1'b0);
    // R10 no select without accValid
    check("R10 invalid ctrl addr", {7'h0, selVec()}, 16'h0000);
    idle();
    check("R11 invalid ctrl write", {4'h0, fieldVec()}, 16'h0695);

    // R9 mid-run reset
    @(negedge clk); rstN = 1'b0;
    #1;
    check("R9 async reset", {4'h0, fieldVec()}, 16'h0000);
    @(negedge clk); rstN = 1'b1;
    idle();
    check("R9 after second reset", {4'h0, fieldVec()}, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule